// File: doc/BRIEF.md
# Simulation IO and Interrupt Injection Slave

This block is a bus slave that lets software running on a simulated processor talk to the test environment. It sits in a fixed address window. It gives software three output channels: a character stream, a 32-bit value stream, and a run-termination code. It also lets software drive the interrupt inputs of the core it runs on, which makes interrupt handlers testable without any other hardware.

There are two interrupt sources a program can drive. The first is a single software-interrupt level. The second is a 32-bit external interrupt vector. Each source has one address that sets bits and a second address that clears them, and both addresses read back the live state. A 64-bit free-running machine timer and a 64-bit compare register complete the block. Software reaches each of them as two 32-bit halves. A pending output is raised while the timer has reached the compare value.

The bus carries a valid, a write flag, an address and write data, and it completes in one cycle. Writes take effect at the clock edge of the cycle that carries them. Read data is returned combinationally in the same cycle, from the state held before that edge. Address decoding is done by `tbio_decode`, which produces a named select code for each register; the select codes are listed in R1.

Top module: `tbio_irq_periph`

## Requirements
- R1: The window is the 4 KiB region whose upper 20 address bits equal those of base 0x80000000. Only these exact offsets are mapped, each with its select code: 0x000 char, 0x004 value, 0x008 exit, 0x010 soft-set, 0x014 soft-clear, 0x020 vector-set, 0x030 vector-clear, 0x100 timer-low, 0x104 timer-high, 0x108 compare-low, 0x10C compare-high. Every other address, including one inside the window at a different offset, selects none. A read of an unselected address returns zero, a write to one changes nothing, and `bus_rdata` is zero in any cycle that is not a read.
- R2: A write to offset 0x000 makes `char_strobe` high for the next cycle only, with `char_data` equal to bits 7:0 of the write data.
- R3: A write to offset 0x004 makes `value_strobe` high for the next cycle, with `value_data` equal to the write data.
- R4: A write to offset 0x008 makes `exit_strobe` high for the next cycle, with `exit_code` equal to the write data.
- R5: A write of any data to offset 0x010 makes `soft_irq` 1 from the next cycle on. A write of any data to offset 0x014 makes it 0.
- R6: A read of 0x010 or 0x014 returns the `soft_irq` level in bit 0, and zero in bits 31:1.
- R7: A write to 0x020 ORs the write data into `ext_irq`. A write to 0x030 clears the `ext_irq` bits that are 1 in the write data.
- R8: A read of 0x020 or 0x030 returns the full `ext_irq` vector.
- R9: The timer increases by one on every clock edge that does not carry a timer write. Offset 0x100 reads the low half and 0x104 the high half, and a carry out of the low half goes into the high half.
- R10: A write to one timer half replaces that half and leaves the other half unchanged. In that cycle the write takes the place of the increment.
- R11: Compare offsets 0x108 (low) and 0x10C (high) are written per half, leaving the other half unchanged, and read back what was written.
- R12: `timer_irq` is 1 exactly when the timer is greater than or equal to the compare value, both taken as unsigned 64-bit numbers.
- R13: After reset, the soft level, the vector, the timer and the compare value are zero, and all strobes are low. `timer_irq` is therefore 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| char_strobe | output | 1 | Character emitted |
| char_data | output | 8 | Character code |
| value_strobe | output | 1 | 32-bit value emitted |
| value_data | output | 32 | Emitted value |
| exit_strobe | output | 1 | Run end requested |
| exit_code | output | 32 | Termination code |
| soft_irq | output | 1 | Software interrupt level |
| ext_irq | output | 32 | External interrupt vector |
| timer_irq | output | 1 | Timer reached compare |

## Verification
Two functions can act on the timer register in the same cycle: the free-running increment and a software write to one of its halves. The bench provokes this collision by writing a low half close to wrap, then writing the high half in the very next cycle. It then reads both halves and compares them against fixed values worked out by hand, which shows that the written cycle skipped its increment and that the carry still reached the high half afterwards. The same thing happens between a compare write and the pending output: random writes to the compare and timer halves change the relation between the two on every access, and `timer_irq` is compared each cycle against a 64-bit comparison made in the bench.

// File: rtl/tbio_pkg.sv
package tbio_pkg;

    localparam int OFF_W = 12;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CHAR,
        SEL_VALUE,
        SEL_EXIT,
        SEL_SOFT_SET,
        SEL_SOFT_CLR,
        SEL_VEC_SET,
        SEL_VEC_CLR,
        SEL_TIME_LO,
        SEL_TIME_HI,
        SEL_CMP_LO,
        SEL_CMP_HI
    } sel_e;

    localparam logic [OFF_W-1:0] OFF_CHAR     = 12'h000;
    localparam logic [OFF_W-1:0] OFF_VALUE    = 12'h004;
    localparam logic [OFF_W-1:0] OFF_EXIT     = 12'h008;
    localparam logic [OFF_W-1:0] OFF_SOFT_SET = 12'h010;
    localparam logic [OFF_W-1:0] OFF_SOFT_CLR = 12'h014;
    localparam logic [OFF_W-1:0] OFF_VEC_SET  = 12'h020;
    localparam logic [OFF_W-1:0] OFF_VEC_CLR  = 12'h030;
    localparam logic [OFF_W-1:0] OFF_TIME_LO  = 12'h100;
    localparam logic [OFF_W-1:0] OFF_TIME_HI  = 12'h104;
    localparam logic [OFF_W-1:0] OFF_CMP_LO   = 12'h108;
    localparam logic [OFF_W-1:0] OFF_CMP_HI   = 12'h10C;

endpackage

// File: rtl/tbio_decode.sv
module tbio_decode
    import tbio_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);

    logic             in_window;
    logic [OFF_W-1:0] offset;

    assign in_window = (addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
    assign offset    = addr[OFF_W-1:0];

    always_comb begin
        sel = SEL_NONE;
        if (in_window) begin
            unique case (offset)
                OFF_CHAR:     sel = SEL_CHAR;
                OFF_VALUE:    sel = SEL_VALUE;
                OFF_EXIT:     sel = SEL_EXIT;
                OFF_SOFT_SET: sel = SEL_SOFT_SET;
                OFF_SOFT_CLR: sel = SEL_SOFT_CLR;
                OFF_VEC_SET:  sel = SEL_VEC_SET;
                OFF_VEC_CLR:  sel = SEL_VEC_CLR;
                OFF_TIME_LO:  sel = SEL_TIME_LO;
                OFF_TIME_HI:  sel = SEL_TIME_HI;
                OFF_CMP_LO:   sel = SEL_CMP_LO;
                OFF_CMP_HI:   sel = SEL_CMP_HI;
                default:      sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/tbio_irq_regs.sv
module tbio_irq_regs
    import tbio_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  sel_e             sel,
    input  logic [VEC_W-1:0] wdata,
    output logic             soft_q,
    output logic [VEC_W-1:0] vec_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
            vec_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_SOFT_SET: soft_q <= 1'b1;
                SEL_SOFT_CLR: soft_q <= 1'b0;
                SEL_VEC_SET:  vec_q  <= vec_q | wdata;
                SEL_VEC_CLR:  vec_q  <= vec_q & ~wdata;
                default: ;
            endcase
        end
    end

    // R5
    soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SOFT_SET) |=> soft_q);

    // R5
    soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SOFT_CLR) |=> !soft_q);

    // R7
    vec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_VEC_SET) |=> ((vec_q & $past(wdata)) == $past(wdata)));

    // R7
    vec_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_VEC_CLR) |=> ((vec_q & $past(wdata)) == '0));

endmodule

// File: rtl/tbio_mtimer.sv
module tbio_mtimer
    import tbio_pkg::*;
#(
    parameter int   HALF_W       = 32,
    parameter logic CMP_RST_ONES = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  sel_e                sel,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] time_q,
    output logic [2*HALF_W-1:0] cmp_q,
    output logic                pending
);

    localparam int TIME_W = 2 * HALF_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (wr_en && sel == SEL_TIME_LO) begin
            time_q[HALF_W-1:0] <= wdata;
        end else if (wr_en && sel == SEL_TIME_HI) begin
            time_q[TIME_W-1:HALF_W] <= wdata;
        end else begin
            time_q <= time_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= {TIME_W{CMP_RST_ONES}};
        end else if (wr_en && sel == SEL_CMP_LO) begin
            cmp_q[HALF_W-1:0] <= wdata;
        end else if (wr_en && sel == SEL_CMP_HI) begin
            cmp_q[TIME_W-1:HALF_W] <= wdata;
        end
    end

    assign pending = (time_q >= cmp_q);

    // R9
    time_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel == SEL_TIME_LO || sel == SEL_TIME_HI))
        |=> time_q == $past(time_q) + 1'b1);

    // R10
    time_lo_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_TIME_LO)
        |=> time_q[TIME_W-1:HALF_W] == $past(time_q[TIME_W-1:HALF_W]));

    // R10
    time_hi_keep_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_TIME_HI)
        |=> time_q[HALF_W-1:0] == $past(time_q[HALF_W-1:0]));

    // R11
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel == SEL_CMP_LO || sel == SEL_CMP_HI)) |=> $stable(cmp_q));

endmodule

// File: rtl/tbio_irq_periph.sv
module tbio_irq_periph
    import tbio_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR    = 32'h8000_0000,
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter int          CHAR_W       = 8,
    parameter logic        CMP_RST_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              char_strobe,
    output logic [CHAR_W-1:0] char_data,
    output logic              value_strobe,
    output logic [DATA_W-1:0] value_data,
    output logic              exit_strobe,
    output logic [DATA_W-1:0] exit_code,
    output logic              soft_irq,
    output logic [DATA_W-1:0] ext_irq,
    output logic              timer_irq
);

    localparam int TIME_W = 2 * DATA_W;

    sel_e              sel;
    logic              wr_en;
    logic              rd_en;
    logic [TIME_W-1:0] time_q;
    logic [TIME_W-1:0] cmp_q;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    tbio_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    tbio_irq_regs #(
        .VEC_W (DATA_W)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (bus_wdata),
        .soft_q (soft_irq),
        .vec_q  (ext_irq)
    );

    tbio_mtimer #(
        .HALF_W       (DATA_W),
        .CMP_RST_ONES (CMP_RST_ONES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (bus_wdata),
        .time_q  (time_q),
        .cmp_q   (cmp_q),
        .pending (timer_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_strobe  <= 1'b0;
            value_strobe <= 1'b0;
            exit_strobe  <= 1'b0;
            char_data    <= '0;
            value_data   <= '0;
            exit_code    <= '0;
        end else begin
            char_strobe  <= wr_en && sel == SEL_CHAR;
            value_strobe <= wr_en && sel == SEL_VALUE;
            exit_strobe  <= wr_en && sel == SEL_EXIT;
            if (wr_en && sel == SEL_CHAR)  char_data  <= bus_wdata[CHAR_W-1:0];
            if (wr_en && sel == SEL_VALUE) value_data <= bus_wdata;
            if (wr_en && sel == SEL_EXIT)  exit_code  <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_SOFT_SET, SEL_SOFT_CLR: bus_rdata = {{(DATA_W-1){1'b0}}, soft_irq};
                SEL_VEC_SET,  SEL_VEC_CLR:  bus_rdata = ext_irq;
                SEL_TIME_LO:                bus_rdata = time_q[DATA_W-1:0];
                SEL_TIME_HI:                bus_rdata = time_q[TIME_W-1:DATA_W];
                SEL_CMP_LO:                 bus_rdata = cmp_q[DATA_W-1:0];
                SEL_CMP_HI:                 bus_rdata = cmp_q[TIME_W-1:DATA_W];
                default:                    bus_rdata = '0;
            endcase
        end
    end

    // R1
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> bus_rdata == '0);

    // R2
    char_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CHAR) |=> char_strobe && char_data == $past(bus_wdata[CHAR_W-1:0]));

    // R4
    exit_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EXIT) |=> exit_strobe && exit_code == $past(bus_wdata));

    // R6
    soft_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == SEL_SOFT_SET || sel == SEL_SOFT_CLR))
        |-> bus_rdata[DATA_W-1:1] == '0);

endmodule

// File: tb/test_tbio_irq_periph.sv
module test_tbio_irq_periph;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        char_strobe;
    logic [7:0]  char_data;
    logic        value_strobe;
    logic [31:0] value_data;
    logic        exit_strobe;
    logic [31:0] exit_code;
    logic        soft_irq;
    logic [31:0] ext_irq;
    logic        timer_irq;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbio_irq_periph i_tbio_irq_periph (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .char_strobe  (char_strobe),
        .char_data    (char_data),
        .value_strobe (value_strobe),
        .value_data   (value_data),
        .exit_strobe  (exit_strobe),
        .exit_code    (exit_code),
        .soft_irq     (soft_irq),
        .ext_irq      (ext_irq),
        .timer_irq    (timer_irq)
    );

    // Reference state built from the requirements
    logic        m_soft;
    logic [31:0] m_vec;
    logic [63:0] m_time;
    logic [63:0] m_cmp;
    logic        m_cs, m_vs, m_es;
    logic [7:0]  m_cd;
    logic [31:0] m_vd, m_ec;

    function automatic logic is_wr(input logic [31:0] off);
        return bus_valid && bus_write && (bus_addr == BASE + off);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_soft <= 1'b0; m_vec <= '0; m_time <= '0; m_cmp <= '0;
            m_cs <= 1'b0; m_vs <= 1'b0; m_es <= 1'b0;
            m_cd <= '0; m_vd <= '0; m_ec <= '0;
        end else begin
            m_cs <= is_wr(32'h000);
            m_vs <= is_wr(32'h004);
            m_es <= is_wr(32'h008);
            if (is_wr(32'h000)) m_cd <= bus_wdata[7:0];
            if (is_wr(32'h004)) m_vd <= bus_wdata;
            if (is_wr(32'h008)) m_ec <= bus_wdata;
            if (is_wr(32'h010)) m_soft <= 1'b1;
            if (is_wr(32'h014)) m_soft <= 1'b0;
            if (is_wr(32'h020)) m_vec <= m_vec | bus_wdata;
            if (is_wr(32'h030)) m_vec <= m_vec & ~bus_wdata;
            if (is_wr(32'h100))      m_time <= {m_time[63:32], bus_wdata};
            else if (is_wr(32'h104)) m_time <= {bus_wdata, m_time[31:0]};
            else                     m_time <= m_time + 64'd1;
            if (is_wr(32'h108)) m_cmp <= {m_cmp[63:32], bus_wdata};
            if (is_wr(32'h10C)) m_cmp <= {bus_wdata, m_cmp[31:0]};
        end
    end

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        case (a)
            BASE + 32'h010, BASE + 32'h014: return {31'd0, m_soft};
            BASE + 32'h020, BASE + 32'h030: return m_vec;
            BASE + 32'h100: return m_time[31:0];
            BASE + 32'h104: return m_time[63:32];
            BASE + 32'h108: return m_cmp[31:0];
            BASE + 32'h10C: return m_cmp[63:32];
            default:        return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Outputs after the edge, sampled at the falling edge
    task automatic check_outputs();
        check("R5", soft_irq, m_soft);
        check("R7", ext_irq, m_vec);
        check("R12", timer_irq, m_time >= m_cmp);
        check("R2", {char_strobe, char_data}, {m_cs, m_cd});
        check("R3", {value_strobe, value_data}, {m_vs, m_vd});
        check("R4", {exit_strobe, exit_code}, {m_es, m_ec});
    endtask

    // One bus cycle; called at a falling edge, returns at the next one
    task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        #1;
        rd = bus_rdata;
        if (!w) check("R1", bus_rdata, exp_read(a));
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check_outputs();
    endtask

    task automatic idle();
        logic [31:0] rd;
        #1;
        check("R1", bus_rdata, 32'd0);
        @(negedge clk);
        check_outputs();
        rd = 0;
    endtask

    logic [31:0] addr_pool [16];

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        addr_pool = '{BASE + 32'h000, BASE + 32'h004, BASE + 32'h008, BASE + 32'h010,
                      BASE + 32'h014, BASE + 32'h020, BASE + 32'h030, BASE + 32'h100,
                      BASE + 32'h104, BASE + 32'h108, BASE + 32'h10C, BASE + 32'h00C,
                      BASE + 32'h024, BASE + 32'h011, 32'h9000_0010, 32'h0000_0020};
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13", {soft_irq, ext_irq}, 33'd0);
        check("R13", {char_strobe, value_strobe, exit_strobe}, 3'b000);
        check("R13", timer_irq, 1'b1);
        access(1'b0, BASE + 32'h108, 0, rd);
        check("R13", rd, 32'd0);

        // R2 R3 R4 directed
        access(1'b1, BASE + 32'h000, 32'h1234_5641, rd);
        check("R2", {char_strobe, char_data}, {1'b1, 8'h41});
        idle();
        check("R2", char_strobe, 1'b0);
        access(1'b1, BASE + 32'h004, 32'hDEAD_BEEF, rd);
        check("R3", value_data, 32'hDEAD_BEEF);
        access(1'b1, BASE + 32'h008, 32'hFFFF_FFFF, rd);
        check("R4", {exit_strobe, exit_code}, {1'b1, 32'hFFFF_FFFF});

        // R5 R6 soft level, any data
        access(1'b1, BASE + 32'h010, 32'h0, rd);
        check("R5", soft_irq, 1'b1);
        access(1'b0, BASE + 32'h014, 0, rd);
        check("R6", rd, 32'd1);
        access(1'b1, BASE + 32'h014, 32'hFFFF_FFFF, rd);
        check("R5", soft_irq, 1'b0);
        access(1'b0, BASE + 32'h010, 0, rd);
        check("R6", rd, 32'd0);

        // R7 R8 vector masks
        access(1'b1, BASE + 32'h020, 32'h0000_00F0, rd);
        access(1'b1, BASE + 32'h020, 32'h8000_0001, rd);
        check("R7", ext_irq, 32'h8000_00F1);
        access(1'b1, BASE + 32'h030, 32'h0000_0030, rd);
        check("R7", ext_irq, 32'h8000_00C1);
        access(1'b0, BASE + 32'h030, 0, rd);
        check("R8", rd, 32'h8000_00C1);

        // R1 unmapped write inside window leaves state alone
        access(1'b1, BASE + 32'h024, 32'hFFFF_FFFF, rd);
        check("R1", ext_irq, 32'h8000_00C1);
        access(1'b0, BASE + 32'h00C, 0, rd);
        check("R1", rd, 32'd0);

        // R10 R9 write collides with increment, carry into high half
        access(1'b1, BASE + 32'h100, 32'hFFFF_FFFE, rd);
        access(1'b1, BASE + 32'h104, 32'h0000_0005, rd);
        access(1'b0, BASE + 32'h100, 0, rd);
        check("R10", rd, 32'hFFFF_FFFE);
        idle();
        access(1'b0, BASE + 32'h104, 0, rd);
        check("R9", rd, 32'h0000_0006);

        // R11 R12 compare above timer clears pending
        access(1'b1, BASE + 32'h10C, 32'h0000_0007, rd);
        check("R12", timer_irq, 1'b0);
        access(1'b0, BASE + 32'h10C, 0, rd);
        check("R11", rd, 32'h0000_0007);
        access(1'b1, BASE + 32'h104, 32'h0000_0007, rd);
        check("R12", timer_irq, 1'b1);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, d;
            logic w;
            a = addr_pool[$urandom_range(15, 0)];
            w = $urandom_range(1, 0) == 1;
            d = $urandom();
            if ($urandom_range(3, 0) == 0) d = d & 32'h0000_000F;
            access(w, a, d, rd);
            if ($urandom_range(7, 0) == 0) idle();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule